// File: doc/BRIEF.md
# Extended-Instruction Mode Gate with Timed Enable

This block sits next to an instruction decoder and decides, each cycle, whether the instruction being decoded may issue or must instead raise an illegal-instruction trap. It does this by checking the instruction against a mode-control register. That register has three active fields. The first is a set of one-hot feature enables, one bit per extended instruction group. The second is a binary mode selector. The third is a small countdown. The countdown switches a user-enabled mode on for a fixed number of retired instructions and then switches it off again without any further write.

Software writes the register through a single write port, and the block reads the register back on `rd_data`. Some of the fields may only be changed at supervisor level. If a user-level write tries to change one of those fields, the block raises a trap and discards the whole write. A retiring branch, or any other PC discontinuity, that occurs while a countdown is running also raises a trap.

When a trap is taken, the block copies the mode state into a shadow register and clears the live state. When the return strobe arrives, it copies the shadow back, so an interrupted countdown continues from where it stopped.

The control path is a three-state machine:

- `ST_FREE`: no countdown is running.
- `ST_TIMED`: a countdown is nonzero.
- `ST_HANDLER`: a trap has been taken and the shadow register holds the saved state.

Its transitions are:

- FREE→TIMED: a write loads a nonzero count.
- TIMED→FREE: the count expires, or a write loads zero.
- FREE/TIMED→HANDLER: trap entry.
- HANDLER→FREE or HANDLER→TIMED: return. The target depends on whether the saved count is nonzero.

Top module: `isa_mode_gate`

## Requirements
- R1: After reset, `rd_data` reads 0 and the state is `ST_FREE`. An instruction of decode class 0 issues.
- R2: Decode class 0 (base) always issues. Decode class 3 (unassigned) always raises `trap_req` and never issues.
- R3: Decode class 1 is gated by one-hot enables. It issues only when `dec_idx` is below 8 and enable bit `dec_idx` (register bits [7:0]) is 1. Otherwise it traps.
- R4: Decode class 2 is gated by the selector. It issues only when `dec_idx` equals the selector (register bits [11:8]) and `dec_idx` is nonzero. Otherwise it traps.
- R5: Register layout: bits [7:0] are enables, [11:8] are the selector, and [15:12] are the countdown. Bits [31:16] always read 0, even when a write carries ones there.
- R6: Enable bit 0 and the selector are privileged. If a write with `priv`=0 carries a different value in either of them, it raises `trap_req` and the register keeps its old content. A user write that leaves both unchanged, and any write with `priv`=1, is applied on the next edge.
- R7: Each retire strobe decrements a nonzero countdown by one. A write that occurs in the same cycle takes precedence, and the retire in that cycle is not counted.
- R8: When the countdown steps from 1 to 0, enable bits [7:1] are cleared. Bit 0 and the selector keep their values.
- R9: A retire with `rt_jump`=1 while the countdown is nonzero raises `trap_req`. The saved copy then holds a countdown of 0 and enable bits [7:1] cleared.
- R10: A trap from `trap_req` or `exc_in`, taken outside `ST_HANDLER`, saves the value the register would otherwise have taken on that edge. It forces the live register to 0 and enters `ST_HANDLER`. Traps raised inside `ST_HANDLER` leave the saved copy untouched.
- R11: `tr_exit` in `ST_HANDLER` restores the saved copy, so a countdown resumes from its saved value. Outside `ST_HANDLER`, `tr_exit` has no effect.
- R12: `issue_ok` and `trap_req` follow the current register value within the same cycle. Register updates appear after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | An instruction is being decoded |
| dec_cls | input | 2 | Decode class: 0 base, 1 enable-gated, 2 selector-gated, 3 unassigned |
| dec_idx | input | IDX_W (4) | Enable bit index or required selector value |
| priv | input | 1 | Current privilege: 1 supervisor, 0 user |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | REG_W (32) | Register write data |
| rt_strobe | input | 1 | One instruction retires this cycle |
| rt_jump | input | 1 | The retiring instruction changed the PC non-sequentially |
| exc_in | input | 1 | External trap entry request |
| tr_exit | input | 1 | Return-from-trap strobe |
| issue_ok | output | 1 | The decoded instruction may issue |
| trap_req | output | 1 | Illegal-instruction trap request |
| rd_data | output | REG_W (32) | Current register value |

## Verification
The bench builds the block with its default parameters: eight enable bits, a four-bit selector and a four-bit countdown. With these values, every enable index, every selector value including the out-of-range and zero cases, and a full fifteen-step countdown run to expiry are all reachable within a short run. Directed sequences cover several situations:

- writes and retires that land in the same cycle;
- jumps taken while a countdown is running;
- nested traps inside the handler;
- returns issued outside the handler.

A long biased-random run then compares a behavioural model against the block on every cycle.

// File: rtl/isa_gate_pkg.sv
package isa_gate_pkg;
    typedef enum logic [1:0] {
        CLS_BASE   = 2'd0,
        CLS_UNARY  = 2'd1,
        CLS_SELECT = 2'd2,
        CLS_RESV   = 2'd3
    } dec_cls_e;

    typedef enum logic [1:0] {
        ST_FREE    = 2'd0,
        ST_TIMED   = 2'd1,
        ST_HANDLER = 2'd2
    } gate_st_e;
endpackage

// File: rtl/isa_perm_check.sv
module isa_perm_check
    import isa_gate_pkg::*;
#(
    parameter int EN_W  = 8,
    parameter int SEL_W = 4,
    parameter int IDX_W = 4
) (
    input  logic [1:0]       cls,
    input  logic [IDX_W-1:0] idx,
    input  logic [EN_W-1:0]  en,
    input  logic [SEL_W-1:0] sel,
    output logic             permit
);
    logic unary_hit;

    // Scan the enable vector so an out-of-range index simply finds nothing.
    always_comb begin
        unary_hit = 1'b0;
        for (int i = 0; i < EN_W; i++) begin
            if (idx == IDX_W'(i)) unary_hit = en[i];
        end
    end

    always_comb begin
        unique case (dec_cls_e'(cls))
            CLS_BASE:   permit = 1'b1;
            CLS_UNARY:  permit = unary_hit;
            CLS_SELECT: permit = (IDX_W'(sel) == idx) && (idx != '0);
            CLS_RESV:   permit = 1'b0;
            default:    permit = 1'b0;
        endcase
    end
endmodule

// File: rtl/isa_mode_next.sv
module isa_mode_next #(
    parameter int EN_W  = 8,
    parameter int SEL_W = 4,
    parameter int CNT_W = 4
) (
    input  logic [EN_W-1:0]  en,
    input  logic [SEL_W-1:0] sel,
    input  logic [CNT_W-1:0] cnt,
    input  logic             wr_en,
    input  logic [EN_W-1:0]  w_en,
    input  logic [SEL_W-1:0] w_sel,
    input  logic [CNT_W-1:0] w_cnt,
    input  logic             priv,
    input  logic             rt_strobe,
    input  logic             rt_jump,
    output logic [EN_W-1:0]  nx_en,
    output logic [SEL_W-1:0] nx_sel,
    output logic [CNT_W-1:0] nx_cnt,
    output logic             priv_viol,
    output logic             jump_viol
);
    localparam logic [EN_W-1:0] USR_EN_M = {{(EN_W-1){1'b1}}, 1'b0};

    assign priv_viol = wr_en && !priv && ((w_en[0] != en[0]) || (w_sel != sel));
    assign jump_viol = rt_strobe && rt_jump && (cnt != '0);

    always_comb begin
        nx_en  = en;
        nx_sel = sel;
        nx_cnt = cnt;
        if (wr_en && !priv_viol) begin
            // the writing instruction is not counted against the countdown
            nx_en  = w_en;
            nx_sel = w_sel;
            nx_cnt = w_cnt;
        end else if (rt_strobe && (cnt != '0)) begin
            nx_cnt = cnt - CNT_W'(1);
            if (cnt == CNT_W'(1)) nx_en = en & ~USR_EN_M;
        end
        if (jump_viol) begin
            nx_cnt = '0;
            nx_en  = nx_en & ~USR_EN_M;
        end
    end
endmodule

// File: rtl/isa_mode_gate.sv
module isa_mode_gate
    import isa_gate_pkg::*;
#(
    parameter int EN_W  = 8,
    parameter int SEL_W = 4,
    parameter int CNT_W = 4,
    parameter int REG_W = 32,
    localparam int IDX_W = (SEL_W > $clog2(EN_W)) ? SEL_W : $clog2(EN_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_valid,
    input  logic [1:0]       dec_cls,
    input  logic [IDX_W-1:0] dec_idx,
    input  logic             priv,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rt_strobe,
    input  logic             rt_jump,
    input  logic             exc_in,
    input  logic             tr_exit,
    output logic             issue_ok,
    output logic             trap_req,
    output logic [REG_W-1:0] rd_data
);
    localparam int SEL_LO = EN_W;
    localparam int CNT_LO = EN_W + SEL_W;
    localparam int PAY_W  = EN_W + SEL_W + CNT_W;
    localparam int PAD_W  = REG_W - PAY_W;

    gate_st_e         state_q, state_d;
    logic [EN_W-1:0]  en_q, en_d, sh_en_q, sh_en_d, nx_en;
    logic [SEL_W-1:0] sel_q, sel_d, sh_sel_q, sh_sel_d, nx_sel;
    logic [CNT_W-1:0] cnt_q, cnt_d, sh_cnt_q, sh_cnt_d, nx_cnt;
    logic             permit, priv_viol, jump_viol, take_trap;
    logic             unused_rsv;

    assign unused_rsv = ^wr_data[REG_W-1:PAY_W];

    isa_perm_check #(.EN_W(EN_W), .SEL_W(SEL_W), .IDX_W(IDX_W)) u_perm (
        .cls(dec_cls), .idx(dec_idx), .en(en_q), .sel(sel_q), .permit(permit)
    );

    isa_mode_next #(.EN_W(EN_W), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_next (
        .en(en_q), .sel(sel_q), .cnt(cnt_q),
        .wr_en(wr_en),
        .w_en(wr_data[EN_W-1:0]),
        .w_sel(wr_data[SEL_LO +: SEL_W]),
        .w_cnt(wr_data[CNT_LO +: CNT_W]),
        .priv(priv), .rt_strobe(rt_strobe), .rt_jump(rt_jump),
        .nx_en(nx_en), .nx_sel(nx_sel), .nx_cnt(nx_cnt),
        .priv_viol(priv_viol), .jump_viol(jump_viol)
    );

    assign issue_ok  = dec_valid && permit;
    assign trap_req  = (dec_valid && !permit) || priv_viol || jump_viol;
    assign take_trap = trap_req || exc_in;
    assign rd_data   = {{PAD_W{1'b0}}, cnt_q, sel_q, en_q};

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FREE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        unique case (state_q)
            ST_FREE, ST_TIMED:
                if (take_trap)          state_d = ST_HANDLER;
                else if (nx_cnt != '0)  state_d = ST_TIMED;
                else                    state_d = ST_FREE;
            ST_HANDLER:
                if (!tr_exit)           state_d = ST_HANDLER;
                else if (sh_cnt_q != '0) state_d = ST_TIMED;
                else                    state_d = ST_FREE;
            default:                    state_d = ST_FREE;
        endcase
    end

    // register contents per state
    always_comb begin
        en_d     = nx_en;
        sel_d    = nx_sel;
        cnt_d    = nx_cnt;
        sh_en_d  = sh_en_q;
        sh_sel_d = sh_sel_q;
        sh_cnt_d = sh_cnt_q;
        unique case (state_q)
            ST_FREE, ST_TIMED:
                if (take_trap) begin
                    sh_en_d  = nx_en;
                    sh_sel_d = nx_sel;
                    sh_cnt_d = nx_cnt;
                    en_d     = '0;
                    sel_d    = '0;
                    cnt_d    = '0;
                end
            ST_HANDLER:
                if (tr_exit) begin
                    en_d  = sh_en_q;
                    sel_d = sh_sel_q;
                    cnt_d = sh_cnt_q;
                end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= '0;
            sel_q    <= '0;
            cnt_q    <= '0;
            sh_en_q  <= '0;
            sh_sel_q <= '0;
            sh_cnt_q <= '0;
        end else begin
            en_q     <= en_d;
            sel_q    <= sel_d;
            cnt_q    <= cnt_d;
            sh_en_q  <= sh_en_d;
            sh_sel_q <= sh_sel_d;
            sh_cnt_q <= sh_cnt_d;
        end
    end
endmodule

// File: rtl/isa_mode_gate_chk.sv
module isa_mode_gate_chk
    import isa_gate_pkg::*;
#(
    parameter int EN_W  = 8,
    parameter int SEL_W = 4,
    parameter int CNT_W = 4,
    parameter int REG_W = 32,
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dec_valid,
    input logic [1:0]       dec_cls,
    input logic [IDX_W-1:0] dec_idx,
    input logic             priv,
    input logic             wr_en,
    input logic             wr_bit0,
    input logic             rt_strobe,
    input logic             rt_jump,
    input logic             exc_in,
    input logic             issue_ok,
    input logic             trap_req,
    input logic [REG_W-1:0] rd_data,
    input logic [1:0]       state_q
);
    localparam int CNT_LO = EN_W + SEL_W;
    localparam int PAY_W  = EN_W + SEL_W + CNT_W;

    logic [CNT_W-1:0] cur_cnt;
    logic             in_handler;
    assign cur_cnt    = rd_data[CNT_LO +: CNT_W];
    assign in_handler = (gate_st_e'(state_q) == ST_HANDLER);

    a_r2_unassigned_traps: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_cls == 2'd3) |-> (trap_req && !issue_ok));

    a_r3_unary_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_cls == 2'd1 && dec_idx < IDX_W'(EN_W) &&
         ((rd_data >> dec_idx) & REG_W'(1)) == '0) |-> trap_req);

    a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[REG_W-1:PAY_W] == '0);

    a_r6_user_priv_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !priv && (wr_bit0 != rd_data[0])) |-> trap_req);

    a_r7_countdown_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_handler && !trap_req && !exc_in && !wr_en && rt_strobe && cur_cnt > CNT_W'(1))
        |=> (cur_cnt == $past(cur_cnt) - CNT_W'(1)));

    a_r9_jump_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_strobe && rt_jump && cur_cnt != '0) |-> trap_req);

    a_r10_entry_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_handler && (trap_req || exc_in)) |=> (rd_data == '0 && in_handler));

    a_r12_issue_needs_decode: assert property (@(posedge clk) disable iff (!rst_n)
        issue_ok |-> (dec_valid && !(dec_cls == 2'd3)));
endmodule

bind isa_mode_gate isa_mode_gate_chk #(
    .EN_W(EN_W), .SEL_W(SEL_W), .CNT_W(CNT_W), .REG_W(REG_W), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_cls(dec_cls),
    .dec_idx(dec_idx), .priv(priv), .wr_en(wr_en), .wr_bit0(wr_data[0]),
    .rt_strobe(rt_strobe), .rt_jump(rt_jump), .exc_in(exc_in),
    .issue_ok(issue_ok), .trap_req(trap_req), .rd_data(rd_data),
    .state_q(state_q)
);

// File: tb/isa_mode_gate_bench.sv
`timescale 1ns/1ps
module isa_mode_gate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_valid = 0, priv = 0, wr_en = 0, rt_strobe = 0, rt_jump = 0;
    logic        exc_in = 0, tr_exit = 0;
    logic [1:0]  dec_cls = 0;
    logic [3:0]  dec_idx = 0;
    logic [31:0] wr_data = 0;
    logic        issue_ok, trap_req;
    logic [31:0] rd_data;

    always #2.5 clk = ~clk;

    isa_mode_gate u_isa_mode_gate (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_cls(dec_cls),
        .dec_idx(dec_idx), .priv(priv), .wr_en(wr_en), .wr_data(wr_data),
        .rt_strobe(rt_strobe), .rt_jump(rt_jump), .exc_in(exc_in),
        .tr_exit(tr_exit), .issue_ok(issue_ok), .trap_req(trap_req),
        .rd_data(rd_data)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    // behavioural reference state
    int m_en = 0, m_sel = 0, m_cnt = 0, s_en = 0, s_sel = 0, s_cnt = 0;
    bit m_h = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int dv, input int cls, input int idx, input int we,
                       input logic [31:0] wd, input int pr, input int rs,
                       input int rj, input int ex, input int tx, input string req);
        int perm, pv, jv, ill, e_trap, n_en, n_sel, n_cnt, e_rd;
        @(negedge clk);
        dec_valid = dv[0]; dec_cls = cls[1:0]; dec_idx = idx[3:0];
        wr_en = we[0]; wr_data = wd; priv = pr[0]; rt_strobe = rs[0];
        rt_jump = rj[0]; exc_in = ex[0]; tr_exit = tx[0];
        #1;
        case (cls)
            0: perm = 1;
            1: perm = (idx < 8) ? ((m_en >> idx) & 1) : 0;
            2: perm = (idx == m_sel && idx != 0) ? 1 : 0;
            default: perm = 0;
        endcase
        ill = (dv != 0 && perm == 0) ? 1 : 0;
        pv  = (we != 0 && pr == 0 &&
               ((wd[0] != m_en[0]) || (int'(wd[11:8]) != m_sel))) ? 1 : 0;
        jv  = (rs != 0 && rj != 0 && m_cnt != 0) ? 1 : 0;
        e_trap = (ill | pv | jv);
        e_rd = (m_cnt << 12) | (m_sel << 8) | m_en;
        check(rd_data == e_rd, req, "rd_data", int'(rd_data), e_rd);
        check(issue_ok == (dv != 0 && perm != 0), req, "issue_ok", int'(issue_ok),
              (dv != 0 && perm != 0) ? 1 : 0);
        check(trap_req == e_trap[0], req, "trap_req", int'(trap_req), e_trap);
        n_en = m_en; n_sel = m_sel; n_cnt = m_cnt;
        if (we != 0 && pv == 0) begin
            n_en = int'(wd[7:0]); n_sel = int'(wd[11:8]); n_cnt = int'(wd[15:12]);
        end else if (rs != 0 && m_cnt != 0) begin
            n_cnt = m_cnt - 1;
            if (m_cnt == 1) n_en = m_en & 1;
        end
        if (jv != 0) begin n_cnt = 0; n_en = n_en & 1; end
        if (!m_h) begin
            if (e_trap != 0 || ex != 0) begin
                s_en = n_en; s_sel = n_sel; s_cnt = n_cnt;
                m_en = 0; m_sel = 0; m_cnt = 0; m_h = 1;
            end else begin
                m_en = n_en; m_sel = n_sel; m_cnt = n_cnt;
            end
        end else if (tx != 0) begin
            m_en = s_en; m_sel = s_sel; m_cnt = s_cnt; m_h = 0;
        end else begin
            m_en = n_en; m_sel = n_sel; m_cnt = n_cnt;
        end
    endtask

    task automatic wr(input int pr, input logic [31:0] wd, input string req);
        cyc(0, 0, 0, 1, wd, pr, 0, 0, 0, 0, req);
    endtask
    task automatic obs(input string req);
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, req);
    endtask
    task automatic ret(input string req);
        cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 1, req);
    endtask

    initial begin
        #(5ns * 200000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        obs("R1");
        obs("R1");
        // R5 layout and reserved bits
        wr(1, 32'hFFFF_FFFF, "R5");
        obs("R5");
        wr(1, 32'h0000_0000, "R5");
        // R2 base and unassigned classes
        cyc(1, 0, 9, 0, 0, 0, 0, 0, 0, 0, "R2");
        cyc(1, 3, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
        ret("R2");
        // R3 unary gating
        wr(1, 32'h0000_0005, "R3");
        cyc(1, 1, 2, 0, 0, 0, 0, 0, 0, 0, "R3");
        cyc(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
        cyc(1, 1, 3, 0, 0, 0, 0, 0, 0, 0, "R3");
        ret("R3");
        cyc(1, 1, 9, 0, 0, 0, 0, 0, 0, 0, "R3");
        ret("R3");
        // R4 selector gating
        wr(1, 32'h0000_0501, "R4");
        cyc(1, 2, 5, 0, 0, 0, 0, 0, 0, 0, "R4");
        cyc(1, 2, 4, 0, 0, 0, 0, 0, 0, 0, "R4");
        ret("R4");
        wr(1, 32'h0000_0001, "R4");
        cyc(1, 2, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
        ret("R4");
        // R6 privileged fields
        wr(1, 32'h0000_0301, "R6");
        wr(0, 32'h0000_0300, "R6");
        obs("R6");
        ret("R6");
        obs("R6");
        wr(0, 32'h0000_0401, "R6");
        ret("R6");
        wr(0, 32'h0000_03F1, "R6");
        obs("R6");
        // R7 and R8 countdown with same-cycle write, then expiry
        cyc(0, 0, 0, 1, 32'h0000_33F1, 0, 1, 0, 0, 0, "R7");
        cyc(1, 1, 4, 0, 0, 0, 1, 0, 0, 0, "R7");
        cyc(1, 1, 4, 0, 0, 0, 0, 0, 0, 0, "R12");
        cyc(1, 1, 4, 0, 0, 0, 1, 0, 0, 0, "R7");
        cyc(1, 1, 4, 0, 0, 0, 1, 0, 0, 0, "R8");
        obs("R8");
        // full-length countdown
        wr(0, 32'h0000_F3F1, "R8");
        for (int i = 0; i < 16; i++) cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R8");
        obs("R8");
        // R9 jump while counting
        wr(0, 32'h0000_23F1, "R9");
        cyc(0, 0, 0, 0, 0, 0, 1, 1, 0, 0, "R9");
        obs("R9");
        ret("R9");
        obs("R9");
        cyc(0, 0, 0, 0, 0, 0, 1, 1, 0, 0, "R9");
        // R10 and R11 external trap, nested trap, resume
        wr(0, 32'h0000_43F1, "R10");
        cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R10");
        cyc(0, 0, 0, 0, 0, 0, 1, 0, 1, 0, "R10");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R10");
        cyc(1, 3, 0, 0, 0, 0, 1, 0, 0, 0, "R10");
        ret("R11");
        cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R11");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R11");
        obs("R11");
        // biased random traffic
        for (int i = 0; i < 6000; i++) begin
            int dv, cls, idx, we, pr, rs, rj, ex, tx;
            logic [31:0] wd;
            dv  = ($urandom % 3 != 0) ? 1 : 0;
            cls = $urandom % 4;
            if (cls == 3 && ($urandom % 4 != 0)) cls = 1;
            idx = $urandom % 16;
            we  = ($urandom % 6 == 0) ? 1 : 0;
            pr  = ($urandom % 2);
            wd  = $urandom;
            if ($urandom % 2 == 0) begin
                wd[0] = 1'(m_en & 1);
                wd[11:8] = 4'(m_sel);
            end
            rs  = ($urandom % 2);
            rj  = ($urandom % 8 == 0) ? 1 : 0;
            ex  = ($urandom % 40 == 0) ? 1 : 0;
            tx  = ($urandom % 4 == 0) ? 1 : 0;
            if (dv != 0 && $urandom % 3 != 0) begin
                dv = ($urandom % 2); cls = 0;
            end
            cyc(dv, cls, idx, we, wd, pr, rs, rj, ex, tx, "R12");
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule